// File: doc/BRIEF.md
# ATA PIO Sector Reader

This block is a hardware bus master that pulls a run of sectors from an ATA-style task-file target into memory without any processor involvement. A one-cycle start pulse hands it a 28-bit logical block address, an 8-bit sector count, a master/slave selector and a destination byte address. The block then programs the target's registers over a small synchronous register bus. It issues the read-sector command and polls the status register until the target is ready. After that it streams 256 sixteen-bit words per sector from the data register into memory.

The register bus is synchronous with the block's clock. During a read strobe the target returns its data combinationally and the block captures it at that clock edge. Every memory write follows its data read by exactly one cycle and lands two bytes above the previous one. The block makes a fresh readiness poll before each sector. It gives up on the transfer if the target reports an error or stays unready for longer than a programmable number of polls.

Top module: `ata_pio_reader`

## Requirements
- R1: In the first cycle after an accepted start, the block writes the sector count to register offset 2.
- R2: In the next three cycles, the LBA bytes go to offsets 3, 4 and 5, in that order: bits 7:0, then 15:8, then 23:16.
- R3: In the next cycle, offset 6 receives the byte 0xE0 | (slave << 4) | LBA[27:24], where bit 4 is 1 for the slave drive.
- R4: In the next cycle, the command 0x20 is written to offset 7. From the following cycle on, offset 7 is read once per cycle. A read strobe and a write strobe are never active together.
- R5: A readiness poll on offset 7 precedes every sector. A status byte s with (s & 0x88) == 0x08 ends the poll, and the data reads start in the next cycle.
- R6: Each sector takes exactly 256 consecutive reads of offset 0. Word k of the transfer is written to memory address dst + 2k one cycle after its read. A sector count of 0 means 256 sectors.
- R7: A status byte with bit 7 (busy) clear and bit 0 (error) set aborts the transfer, even if bit 3 is also set. In that case `error` pulses high for one cycle in the next cycle, with `timeout` low and `busy` low, and no further bus cycles follow. A status byte with error set while busy is set does not abort.
- R8: If max(poll_limit, 1) consecutive polls before one sector all find the target unready, `error` and `timeout` pulse together in the next cycle and the transfer ends. The poll counter restarts for every sector.
- R9: `done` pulses for one cycle in the cycle after the last memory write, and `busy` is low in that cycle.
- R10: `busy` is high from the cycle after an accepted start until the completion or abort cycle. A start pulse or a change of the request inputs while busy has no effect on the transfer.
- R11: After reset, both bus strobes, `mem_we`, `busy`, `done`, `error` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| lba | input | 28 | First sector address |
| sec_count | input | 8 | Number of sectors, 0 meaning 256 |
| slave | input | 1 | Selects the slave drive when high |
| dst_addr | input | AW | Destination byte address of the first word |
| poll_limit | input | PW | Maximum polls per sector before timing out |
| bus_addr | output | 3 | Register offset of the current bus cycle |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_wdata | output | 8 | Register write data |
| bus_rdata | input | 16 | Register read data, valid during bus_rd |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle abort pulse |
| timeout | output | 1 | Marks an abort caused by poll timeout |

## Verification
The six register writes are due on the six cycles that follow the edge at which start is taken. Each poll read occupies one cycle. The first data read is due on the cycle after the poll that sees readiness, and each memory write is due one cycle after its data read. `done` is due one cycle after the final write, and `error` is due one cycle after the poll that decides the abort. From the status script it feeds the target, the bench precomputes one expected output vector per cycle. It compares the whole port vector against that list at every falling edge, so an event that arrives a cycle early or late shows up as a mismatch in that cycle.

// File: rtl/ata_rd_pkg.sv
package ata_rd_pkg;

    localparam logic [2:0] REG_DATA    = 3'd0;
    localparam logic [2:0] REG_SECCNT  = 3'd2;
    localparam logic [2:0] REG_LBA_LO  = 3'd3;
    localparam logic [2:0] REG_LBA_MID = 3'd4;
    localparam logic [2:0] REG_LBA_HI  = 3'd5;
    localparam logic [2:0] REG_DEVSEL  = 3'd6;
    localparam logic [2:0] REG_CMDSTAT = 3'd7;

    localparam logic [7:0] CMD_READ_SECT = 8'h20;
    localparam logic [7:0] STAT_MASK     = 8'h88;
    localparam logic [7:0] STAT_READY    = 8'h08;
    localparam logic [7:0] DEV_BASE      = 8'hE0;

    typedef enum logic [3:0] {
        S_IDLE, S_CNT, S_LBA0, S_LBA1, S_LBA2, S_DEV, S_CMD, S_POLL, S_DATA, S_FIN
    } seq_state_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [2:0] addr;
        logic [7:0] wdata;
    } bus_cmd_t;

    typedef struct packed {
        logic [27:0] lba;
        logic [7:0]  count;
        logic        slave;
    } xfer_req_t;

    function automatic logic [7:0] dev_byte(input logic [3:0] lba_top, input logic slv);
        return DEV_BASE | {3'b000, slv, lba_top};
    endfunction

    function automatic logic stat_ready(input logic [7:0] s);
        return (s & STAT_MASK) == STAT_READY;
    endfunction

    function automatic logic stat_fault(input logic [7:0] s);
        return !s[7] && s[0];
    endfunction

endpackage

// File: rtl/ata_rd_poll.sv
module ata_rd_poll
    import ata_rd_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [7:0]    status,
    input  logic [PW-1:0] limit,
    output logic          ready,
    output logic          fault,
    output logic          expired
);
    logic [PW-1:0] cnt_q;
    logic [PW:0]   tries;

    assign fault   = active && stat_fault(status);
    assign ready   = active && !fault && stat_ready(status);
    assign tries   = {1'b0, cnt_q} + {{PW{1'b0}}, 1'b1};
    assign expired = active && !fault && !ready && (tries >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (!ready && !fault && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: leaving the poll clears the attempt count
    p_count_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        !active |=> cnt_q == '0);

    // R8: never more attempts than the limit (at least one)
    p_count_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        (active && limit != '0) |-> ({1'b0, cnt_q} < {1'b0, limit}));

    // R5: at most one poll outcome per cycle
    p_one_outcome_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ready, fault, expired}));

endmodule

// File: rtl/ata_rd_xfer.sv
module ata_rd_xfer #(
    parameter int AW  = 20,
    parameter int WPS = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [7:0]    count,
    input  logic [AW-1:0] dst,
    input  logic          word_stb,
    input  logic [15:0]   rdata,
    output logic          last_word,
    output logic          last_sector,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata
);
    localparam int WIW = $clog2(WPS);
    localparam int SCW = 9;
    localparam logic [WIW-1:0] WORD_LAST = WIW'(WPS - 1);

    logic [WIW-1:0] word_q;
    logic [SCW-1:0] sec_left_q;
    logic [AW-1:0]  ptr_q;

    assign last_word   = word_q == WORD_LAST;
    assign last_sector = sec_left_q == SCW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q     <= '0;
            sec_left_q <= '0;
            ptr_q      <= '0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            mem_we <= word_stb;
            if (load) begin
                word_q     <= '0;
                sec_left_q <= (count == 8'd0) ? SCW'(256) : SCW'(count);
                ptr_q      <= dst;
            end else if (word_stb) begin
                mem_addr  <= ptr_q;
                mem_wdata <= rdata;
                ptr_q     <= ptr_q + AW'(2);
                word_q    <= last_word ? '0 : word_q + 1'b1;
                if (last_word) begin
                    sec_left_q <= sec_left_q - 1'b1;
                end
            end
        end
    end

    // R6: consecutive writes step by one 16-bit word
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + AW'(2));

    // R6: no data read once all sectors are consumed
    p_sector_left_r6: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> sec_left_q != '0);

endmodule

// File: rtl/ata_rd_seq.sv
module ata_rd_seq
    import ata_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  xfer_req_t req,
    input  logic      poll_ready,
    input  logic      poll_fault,
    input  logic      poll_expired,
    input  logic      last_word,
    input  logic      last_sector,
    output bus_cmd_t  cmd,
    output logic      load,
    output logic      poll_active,
    output logic      word_stb,
    output logic      busy,
    output logic      done,
    output logic      error,
    output logic      timeout
);
    seq_state_e state_q, state_d;
    xfer_req_t  req_q;

    assign load        = (state_q == S_IDLE) && start;
    assign poll_active = state_q == S_POLL;
    assign word_stb    = state_q == S_DATA;
    assign busy        = state_q != S_IDLE;

    always_comb begin
        cmd = '0;
        case (state_q)
            S_CNT:  begin cmd.wr = 1'b1; cmd.addr = REG_SECCNT;  cmd.wdata = req_q.count;       end
            S_LBA0: begin cmd.wr = 1'b1; cmd.addr = REG_LBA_LO;  cmd.wdata = req_q.lba[7:0];    end
            S_LBA1: begin cmd.wr = 1'b1; cmd.addr = REG_LBA_MID; cmd.wdata = req_q.lba[15:8];   end
            S_LBA2: begin cmd.wr = 1'b1; cmd.addr = REG_LBA_HI;  cmd.wdata = req_q.lba[23:16];  end
            S_DEV:  begin
                cmd.wr    = 1'b1;
                cmd.addr  = REG_DEVSEL;
                cmd.wdata = dev_byte(req_q.lba[27:24], req_q.slave);
            end
            S_CMD:  begin cmd.wr = 1'b1; cmd.addr = REG_CMDSTAT; cmd.wdata = CMD_READ_SECT;     end
            S_POLL: begin cmd.rd = 1'b1; cmd.addr = REG_CMDSTAT; end
            S_DATA: begin cmd.rd = 1'b1; cmd.addr = REG_DATA;    end
            default: ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: if (start) state_d = S_CNT;
            S_CNT:  state_d = S_LBA0;
            S_LBA0: state_d = S_LBA1;
            S_LBA1: state_d = S_LBA2;
            S_LBA2: state_d = S_DEV;
            S_DEV:  state_d = S_CMD;
            S_CMD:  state_d = S_POLL;
            S_POLL: begin
                if (poll_fault || poll_expired) state_d = S_IDLE;
                else if (poll_ready)            state_d = S_DATA;
            end
            S_DATA: if (last_word) state_d = last_sector ? S_FIN : S_POLL;
            S_FIN:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
            timeout <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) req_q <= req;
            done    <= state_q == S_FIN;
            error   <= poll_active && (poll_fault || poll_expired);
            timeout <= poll_active && poll_expired;
        end
    end

    // R4: the bus carries one direction per cycle
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && cmd.rd));

    // R4: the command write is followed by a status read
    p_poll_after_cmd_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.addr == REG_CMDSTAT) |=> (cmd.rd && cmd.addr == REG_CMDSTAT));

    // R10: the captured request is frozen while a transfer runs
    p_req_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_q));

    // R9: completion comes with the block idle and no abort
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !error));

    // R8: a timeout is always reported as an abort
    p_timeout_is_error_r8: assert property (@(posedge clk) disable iff (rst)
        timeout |-> error);

endmodule

// File: rtl/ata_pio_reader.sv
module ata_pio_reader
    import ata_rd_pkg::*;
#(
    parameter int AW  = 20,
    parameter int PW  = 16,
    parameter int WPS = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [27:0]   lba,
    input  logic [7:0]    sec_count,
    input  logic          slave,
    input  logic [AW-1:0] dst_addr,
    input  logic [PW-1:0] poll_limit,
    output logic [2:0]    bus_addr,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [7:0]    bus_wdata,
    input  logic [15:0]   bus_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          timeout
);
    xfer_req_t req;
    bus_cmd_t  cmd;
    logic      load, poll_active, word_stb;
    logic      poll_ready, poll_fault, poll_expired;
    logic      last_word, last_sector;

    assign req       = '{lba: lba, count: sec_count, slave: slave};
    assign bus_addr  = cmd.addr;
    assign bus_wr    = cmd.wr;
    assign bus_rd    = cmd.rd;
    assign bus_wdata = cmd.wdata;

    ata_rd_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .req          (req),
        .poll_ready   (poll_ready),
        .poll_fault   (poll_fault),
        .poll_expired (poll_expired),
        .last_word    (last_word),
        .last_sector  (last_sector),
        .cmd          (cmd),
        .load         (load),
        .poll_active  (poll_active),
        .word_stb     (word_stb),
        .busy         (busy),
        .done         (done),
        .error        (error),
        .timeout      (timeout)
    );

    ata_rd_poll #(.PW(PW)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .active  (poll_active),
        .status  (bus_rdata[7:0]),
        .limit   (poll_limit),
        .ready   (poll_ready),
        .fault   (poll_fault),
        .expired (poll_expired)
    );

    ata_rd_xfer #(.AW(AW), .WPS(WPS)) u_xfer (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .count       (sec_count),
        .dst         (dst_addr),
        .word_stb    (word_stb),
        .rdata       (bus_rdata),
        .last_word   (last_word),
        .last_sector (last_sector),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

endmodule

// File: tb/tb_ata_pio_reader.sv
`timescale 1ns/1ps
module tb_ata_pio_reader;
    localparam int AW = 20;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst, start, slave;
    logic [27:0]   lba;
    logic [7:0]    sec_count;
    logic [AW-1:0] dst_addr;
    logic [PW-1:0] poll_limit;
    logic [2:0]    bus_addr;
    logic          bus_wr, bus_rd;
    logic [7:0]    bus_wdata;
    logic [15:0]   bus_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          busy, done, error, timeout;

    always #2.5 clk = ~clk;

    ata_pio_reader #(.AW(AW), .PW(PW)) dut (
        .clk(clk), .rst(rst), .start(start), .lba(lba), .sec_count(sec_count),
        .slave(slave), .dst_addr(dst_addr), .poll_limit(poll_limit),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .error(error), .timeout(timeout)
    );

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [2:0]    addr;
        logic [7:0]    wd;
        logic          we;
        logic [AW-1:0] ma;
        logic [15:0]   md;
        logic          bz;
        logic          dn;
        logic          er;
        logic          tm;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;

    // target model: scripted status bytes, generated data words
    logic [7:0] scr [0:7];
    int         scr_n    = 0;
    int         tgt_i    = 0;
    int         rd_words = 0;
    logic [7:0] cur_status;

    function automatic logic [15:0] dword(input int k);
        return 16'h5A00 ^ 16'(k * 311);
    endfunction

    assign cur_status = (tgt_i < scr_n) ? scr[tgt_i] : 8'h58;
    assign bus_rdata  = (bus_addr == 3'd7) ? {8'h00, cur_status} : dword(rd_words);

    always @(posedge clk) begin
        if (bus_rd) begin
            if (bus_addr == 3'd7)      tgt_i    <= tgt_i + 1;
            else if (bus_addr == 3'd0) rd_words <= rd_words + 1;
        end
    end

    // expected-trace builder
    logic          p_we;
    logic [AW-1:0] p_ma;
    logic [15:0]   p_md;

    task automatic push(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] wd,
                        input logic bz, input logic dn, input logic er, input logic tm,
                        input string tg);
        obs_t e;
        e.wr = wr; e.rd = rd; e.addr = a; e.wd = wr ? wd : 8'h00;
        e.we = p_we; e.ma = p_we ? p_ma : '0; e.md = p_we ? p_md : 16'h0;
        e.bz = bz; e.dn = dn; e.er = er; e.tm = tm;
        p_we = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    task automatic build(input int cnt, input logic [27:0] a, input logic slv,
                         input logic [AW-1:0] dst, input int lim);
        int k;
        int si;
        int nsec;
        int n;
        int lim_eff;
        logic [7:0] st;
        k = 0; si = 0; p_we = 1'b0;
        nsec = (cnt == 0) ? 256 : cnt;
        lim_eff = (lim == 0) ? 1 : lim;
        push(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R10");                        // start cycle
        push(1, 0, 3'd2, 8'(cnt), 1, 0, 0, 0, "R1");
        push(1, 0, 3'd3, a[7:0],  1, 0, 0, 0, "R2");
        push(1, 0, 3'd4, a[15:8], 1, 0, 0, 0, "R2");
        push(1, 0, 3'd5, a[23:16], 1, 0, 0, 0, "R2");
        push(1, 0, 3'd6, 8'hE0 | {3'b000, slv, a[27:24]}, 1, 0, 0, 0, "R3");
        push(1, 0, 3'd7, 8'h20, 1, 0, 0, 0, "R4");
        for (int s = 0; s < nsec; s++) begin
            n = 0;
            forever begin
                st = (si < scr_n) ? scr[si] : 8'h58;
                si++; n++;
                push(0, 1, 3'd7, 8'h00, 1, 0, 0, 0, "R5");
                if (!st[7] && st[0]) begin
                    push(0, 0, 3'd0, 8'h00, 0, 0, 1, 0, "R7");
                    push(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R7");
                    return;
                end
                if ((st & 8'h88) == 8'h08) break;
                if (n >= lim_eff) begin
                    push(0, 0, 3'd0, 8'h00, 0, 0, 1, 1, "R8");
                    push(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R8");
                    return;
                end
            end
            for (int w = 0; w < 256; w++) begin
                push(0, 1, 3'd0, 8'h00, 1, 0, 0, 0, "R6");
                p_we = 1'b1; p_ma = dst + AW'(2 * k); p_md = dword(k);
                k++;
            end
        end
        push(0, 0, 3'd0, 8'h00, 1, 0, 0, 0, "R6");
        push(0, 0, 3'd0, 8'h00, 0, 1, 0, 0, "R9");
        push(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R9");
    endtask

    // per-cycle comparison at the falling edge
    obs_t  act_v, exp_v;
    string tag_v;

    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_v = exp_q.pop_front();
            tag_v = tag_q.pop_front();
            act_v.wr = bus_wr; act_v.rd = bus_rd; act_v.addr = bus_addr;
            act_v.wd = bus_wr ? bus_wdata : 8'h00;
            act_v.we = mem_we; act_v.ma = mem_we ? mem_addr : '0;
            act_v.md = mem_we ? mem_wdata : 16'h0;
            act_v.bz = busy; act_v.dn = done; act_v.er = error; act_v.tm = timeout;
            checks++;
            if (act_v !== exp_v) begin
                fails++;
                $display("FAIL %s t=%0t actual=%h expected=%h", tag_v, $time, act_v, exp_v);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic load_script(input logic [7:0] v [0:7], input int n);
        for (int i = 0; i < 8; i++) scr[i] = v[i];
        scr_n = n;
    endtask

    task automatic run(input int cnt, input logic [27:0] a, input logic slv,
                       input logic [AW-1:0] dst, input int lim, input bit disturb);
        @(posedge clk); #1;
        tgt_i = 0; rd_words = 0;
        build(cnt, a, slv, dst, lim);
        lba = a; sec_count = 8'(cnt); slave = slv; dst_addr = dst; poll_limit = PW'(lim);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            // R10: a second start and new inputs during a transfer are ignored
            repeat (3) @(posedge clk);
            #1;
            start = 1'b1; lba = 28'h5555555; sec_count = 8'd7; slave = ~slv; dst_addr = '0;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; slave = 1'b0; lba = '0; sec_count = '0;
        dst_addr = '0; poll_limit = '0;
        for (int i = 0; i < 8; i++) scr[i] = 8'h58;
        repeat (2) @(posedge clk);
        #1;
        // R11: reset state
        p_we = 1'b0;
        push(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R11");
        push(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R11");
        @(posedge clk); #1;
        rst = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);

        // R5 R7: unready patterns, error bit with busy set does not abort
        load_script('{8'h88, 8'h80, 8'hD0, 8'h81, 8'h58, 8'h58, 8'h58, 8'h58}, 5);
        run(1, 28'h0000002, 1'b0, 20'h00900, 50, 1'b0);

        // R3 R5 R10: three sectors, slave, re-poll per sector, start while busy
        load_script('{8'h58, 8'h80, 8'h80, 8'h58, 8'hD8, 8'h58, 8'h58, 8'h58}, 6);
        run(3, 28'hABCDEF1, 1'b1, 20'h02000, 10, 1'b1);

        // R7: error reported before the second sector
        load_script('{8'h58, 8'h80, 8'h51, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58}, 3);
        run(2, 28'h0123456, 1'b0, 20'h00100, 10, 1'b0);

        // R7: error wins over a set data-request bit
        load_script('{8'h59, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58}, 1);
        run(1, 28'h7654321, 1'b1, 20'h00040, 10, 1'b0);

        // R8: timeout after four unready polls
        load_script('{8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80}, 8);
        run(1, 28'h0000010, 1'b0, 20'h00200, 4, 1'b0);

        // R8: limit 0 allows one poll
        load_script('{8'h80, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58}, 1);
        run(1, 28'h0000011, 1'b0, 20'h00200, 0, 1'b0);

        // R8: the poll count restarts for the second sector
        load_script('{8'h80, 8'h58, 8'h88, 8'h88, 8'h88, 8'h58, 8'h58, 8'h58}, 5);
        run(2, 28'hF000020, 1'b1, 20'h00300, 3, 1'b0);

        // R6 R9: sector count 0 reads 256 sectors
        load_script('{8'h58, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58, 8'h58}, 0);
        run(0, 28'h0000100, 1'b0, 20'h10000, 5, 1'b0);

        summary();
    end

endmodule